// File: doc/BRIEF.md
# Dual 56-bit Down-Counter Timer

This peripheral holds two identical timer channels that are programmed and observed over a simple 32-bit register port. The port has an address, a write strobe, write data and a combinational read-data return. Each channel keeps a 56-bit interval and a 56-bit current count. A channel counts down by one on every clock cycle in which the shared `tick_i` strobe is high. It runs either periodically, reloading its interval whenever it expires, or as a one-shot, stopping at zero after one expiry.

Every expiry latches a pending flag for that channel. A shared enable register selects which pending flags drive the single level interrupt output, and software clears a flag by writing a one to it. When the interval is all ones, the bitwise inverse of the current count gives a free-running elapsed-tick count. This lets one channel serve as a time base while the other raises events. Clearing a channel's enable does not stop it at once: the counter keeps following ticks for a fixed two-cycle drain window, then freezes.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every readable register reads 0 and `irq_o` is low.
- R2: Register 0x00 is the interrupt enable register (bit n enables channel n). Register 0x04 is the status register (bit n is channel n pending). Channel n has a window at 0x20+0x20*n holding control (+0x00), interval low (+0x04), current low (+0x08), interval high (+0x0C) and current high (+0x10). The low registers carry count bits 31:0. The high registers carry bits 55:32 in bits 23:0, and bits 31:24 read 0.
- R3: A control write with bit 1 (reload) set copies the 56-bit interval into the current count on the following clock edge. Bit 1 always reads back 0.
- R4: While control bit 0 (enable) is 1, the current count decrements by one on each clock edge where `tick_i` is high. For an all-ones interval, the inverse of the current count equals the number of ticks counted.
- R5: With control bit 7 clear (periodic), a tick arriving at count zero sets the channel's status bit, reloads the interval and leaves enable set.
- R6: With control bit 7 set (one-shot), a tick arriving at count zero sets the status bit, clears enable in hardware, and the count then holds at zero under further ticks.
- R7: After a write clears enable, the counter still follows `tick_i` on the two clock edges after the write edge, and then no longer changes.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some channel has both its status bit and its interrupt-enable bit set.
- R10: Writes to the current-value registers are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe shared by both channels |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
The bench stops a running channel while ticks keep arriving and reads the count exactly three ticks lower. A design with no drain window, or with a longer one, leaves a different value. It runs a one-shot channel past expiry to check that the count stays at zero and enable drops; a design that reloads would show a nonzero count or a second status set. It checks that the reload bit acts only one edge later, so a design that reloads only while enabled, or that reads the bit back, would fail. It also checks that writing 0 to status has no effect, that the high halves are masked to 24 bits, and that writes to the current-value registers and unmapped reads change nothing.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int REG_W      = 32;
  localparam int OFF_IEN    = 'h00;
  localparam int OFF_STS    = 'h04;
  localparam int WIN_STRIDE = 'h20;
  localparam int WIN_SH     = $clog2(WIN_STRIDE);
  localparam int OFF_CTL    = 'h00;
  localparam int OFF_IVL    = 'h04;
  localparam int OFF_CVL    = 'h08;
  localparam int OFF_IVH    = 'h0C;
  localparam int OFF_CVH    = 'h10;
  localparam int CTL_EN     = 0;
  localparam int CTL_RLD    = 1;
  localparam int CTL_ONE    = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_IVL, SEL_CVL, SEL_IVH, SEL_CVH
  } win_sel_e;
endpackage

// File: rtl/dtmr_stop_dly.sv
module dtmr_stop_dly #(
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic hold_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (stop_i)      cnt_q <= CW'(LAT);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);

  p_drain_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> hold_o);
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int CNT_W    = 56,
  parameter int LO_W     = 32,
  parameter int STOP_LAT = 2,
  localparam int HI_W    = CNT_W - LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctl_we_i,
  input  logic             ivl_we_i,
  input  logic             ivh_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             en_o,
  output logic             one_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic             en_q, one_q, rld_q;
  logic [CNT_W-1:0] intv_q, cur_q;
  logic             hold, run, sw_stop;

  assign sw_stop  = ctl_we_i && !wdata_i[CTL_EN] && en_q;
  assign run      = en_q || hold;
  assign expire_o = run && tick_i && !rld_q && (cur_q == '0);

  dtmr_stop_dly #(.LAT(STOP_LAT)) u_stop (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(sw_stop),
    .hold_o(hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      one_q <= 1'b0;
      rld_q <= 1'b0;
    end else if (ctl_we_i) begin
      en_q  <= wdata_i[CTL_EN];
      one_q <= wdata_i[CTL_ONE];
      rld_q <= wdata_i[CTL_RLD];
    end else begin
      rld_q <= 1'b0;
      if (expire_o && one_q) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intv_q <= '0;
    else begin
      if (ivl_we_i) intv_q[LO_W-1:0]     <= wdata_i[LO_W-1:0];
      if (ivh_we_i) intv_q[CNT_W-1:LO_W] <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cur_q <= '0;
    else if (rld_q)             cur_q <= intv_q;
    else if (run && tick_i) begin
      if (cur_q != '0)          cur_q <= cur_q - 1'b1;
      else if (!one_q)          cur_q <= intv_q;
    end
  end

  assign en_o   = en_q;
  assign one_o  = one_q;
  assign intv_o = intv_q;
  assign cur_o  = cur_q;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_q |=> (cur_q == $past(intv_q)));
  p_periodic_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !one_q && !ctl_we_i) |=> (en_q && cur_q == $past(intv_q)));
  p_oneshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && one_q && !ctl_we_i) |=> (!en_q && cur_q == '0));
  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !rld_q) |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ien_we_i,
  input  logic            sts_we_i,
  input  logic [N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0] set_i,
  output logic [N_CH-1:0] ien_o,
  output logic [N_CH-1:0] sts_o,
  output logic            irq_o
);
  logic [N_CH-1:0] ien_q, sts_q, clr_m;

  assign clr_m = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i;
      sts_q <= (sts_q & ~clr_m) | set_i;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_we_i |=> ((sts_q & $past(wdata_i & ~set_i)) == '0));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_m)) == $past(sts_q & ~clr_m)));
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
  import dtmr_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 56,
  parameter int LO_W     = 32,
  parameter int STOP_LAT = 2,
  localparam int HI_W    = CNT_W - LO_W,
  localparam int IDX_W   = ADDR_W - WIN_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [WIN_SH-1:0] off;
  win_sel_e          sel;
  logic [N_CH-1:0]   hit, expire, en, one, ien, sts;
  logic [CNT_W-1:0]  intv [N_CH];
  logic [CNT_W-1:0]  cur  [N_CH];
  logic              ien_hit, sts_hit, rd_hi;

  assign off     = addr_i[WIN_SH-1:0];
  assign ien_hit = (addr_i == ADDR_W'(OFF_IEN));
  assign sts_hit = (addr_i == ADDR_W'(OFF_STS));

  always_comb begin
    case (off)
      WIN_SH'(OFF_CTL): sel = SEL_CTL;
      WIN_SH'(OFF_IVL): sel = SEL_IVL;
      WIN_SH'(OFF_CVL): sel = SEL_CVL;
      WIN_SH'(OFF_IVH): sel = SEL_IVH;
      WIN_SH'(OFF_CVH): sel = SEL_CVH;
      default:          sel = SEL_NONE;
    endcase
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    assign hit[n] = (addr_i[ADDR_W-1:WIN_SH] == IDX_W'(n + 1));

    dtmr_chan #(
      .CNT_W   (CNT_W),
      .LO_W    (LO_W),
      .STOP_LAT(STOP_LAT)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .ctl_we_i(we_i && hit[n] && sel == SEL_CTL),
      .ivl_we_i(we_i && hit[n] && sel == SEL_IVL),
      .ivh_we_i(we_i && hit[n] && sel == SEL_IVH),
      .wdata_i (wdata_i),
      .en_o    (en[n]),
      .one_o   (one[n]),
      .intv_o  (intv[n]),
      .cur_o   (cur[n]),
      .expire_o(expire[n])
    );
  end

  dtmr_irq #(.N_CH(N_CH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_we_i(we_i && ien_hit),
    .sts_we_i(we_i && sts_hit),
    .wdata_i (wdata_i[N_CH-1:0]),
    .set_i   (expire),
    .ien_o   (ien),
    .sts_o   (sts),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    rd_hi   = 1'b0;
    if (ien_hit) rdata_o[N_CH-1:0] = ien;
    if (sts_hit) rdata_o[N_CH-1:0] = sts;
    for (int n = 0; n < N_CH; n++) begin
      if (hit[n]) begin
        case (sel)
          SEL_CTL: begin
            rdata_o[CTL_EN]  = en[n];
            rdata_o[CTL_ONE] = one[n];
          end
          SEL_IVL: rdata_o = intv[n][LO_W-1:0];
          SEL_CVL: rdata_o = cur[n][LO_W-1:0];
          SEL_IVH: begin rdata_o = REG_W'(intv[n][CNT_W-1:LO_W]); rd_hi = 1'b1; end
          SEL_CVH: begin rdata_o = REG_W'(cur[n][CNT_W-1:LO_W]);  rd_hi = 1'b1; end
          default: rdata_o = '0;
        endcase
      end
    end
  end

  p_hi_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |-> (rdata_o[REG_W-1:HI_W] == '0));
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((sts & ien) != '0));
endmodule

// File: tb/dual_dntimer_test.sv
module dual_dntimer_test;
  logic        clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  dual_dntimer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expectations and compares against live outputs
  initial forever begin
    item_t it;
    logic [31:0] act;
    wait (q.size() > 0);
    it  = q.pop_front();
    act = it.is_irq ? {31'b0, irq} : rdata;
    n_run++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk); addr = a; #1;
    it.is_irq = 0; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic chk_irq(input bit e, input string t);
    item_t it;
    @(negedge clk); #1;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = t;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(8'h20, 0, "R1 ctl0");
    rd(8'h28, 0, "R1 cvl0");
    rd(8'h04, 0, "R1 sts");
    rd(8'h00, 0, "R1 ien");
    chk_irq(0, "R1 irq");
    // R2 interval halves
    wr(8'h24, 32'hDEADBEEF);
    wr(8'h2C, 32'hFFABCDEF);
    rd(8'h24, 32'hDEADBEEF, "R2 ivl0");
    rd(8'h2C, 32'h00ABCDEF, "R2 ivh0 pad");
    rd(8'h28, 0, "R3 no load before reload");
    // R3 reload without enable
    wr(8'h20, 32'h2);
    idle(1);
    rd(8'h28, 32'hDEADBEEF, "R3 cvl0 loaded");
    rd(8'h30, 32'h00ABCDEF, "R3 cvh0 loaded");
    rd(8'h20, 0, "R3 reload reads 0");
    // R10 read-only and unmapped
    wr(8'h28, 32'h5);
    wr(8'h30, 32'h7);
    rd(8'h28, 32'hDEADBEEF, "R10 cvl write ignored");
    rd(8'h30, 32'h00ABCDEF, "R10 cvh write ignored");
    rd(8'h34, 0, "R10 unmapped in window");
    rd(8'h70, 0, "R10 unmapped window");
    rd(8'h08, 0, "R10 unmapped low");
    // R4 countdown
    wr(8'h24, 10); wr(8'h2C, 0);
    wr(8'h20, 32'h3);
    idle(1);
    run_ticks(4);
    rd(8'h28, 6, "R4 count after 4 ticks");
    rd(8'h20, 1, "R4 enabled");
    // R7 stop latency with ticks continuing
    @(negedge clk); tick = 1; addr = 8'h20; wdata = 0; we = 1;
    @(posedge clk); #1 we = 0;
    repeat (4) @(posedge clk);
    #1 tick = 0;
    rd(8'h28, 3, "R7 two-cycle drain");
    rd(8'h20, 0, "R7 enable cleared");
    // R5 periodic expiry, R9 masking
    wr(8'h24, 2);
    wr(8'h20, 32'h3);
    idle(1);
    run_ticks(3);
    rd(8'h04, 1, "R5 status set");
    rd(8'h28, 2, "R5 reloaded");
    rd(8'h20, 1, "R5 still enabled");
    chk_irq(0, "R9 masked");
    wr(8'h00, 1);
    chk_irq(1, "R9 enabled irq");
    // R8 write-one-to-clear
    wr(8'h04, 0);
    rd(8'h04, 1, "R8 write 0 keeps");
    chk_irq(1, "R8 irq held");
    wr(8'h04, 1);
    rd(8'h04, 0, "R8 write 1 clears");
    chk_irq(0, "R9 irq drops");
    wr(8'h20, 0);
    idle(3);
    // R6 one-shot on channel 1
    wr(8'h44, 1); wr(8'h4C, 0);
    wr(8'h40, 32'h83);
    idle(1);
    run_ticks(5);
    rd(8'h40, 32'h80, "R6 enable cleared");
    rd(8'h48, 0, "R6 holds zero");
    rd(8'h04, 2, "R6 status ch1");
    chk_irq(0, "R9 ch1 not enabled");
    wr(8'h00, 3);
    chk_irq(1, "R9 ch1 irq");
    wr(8'h04, 2);
    chk_irq(0, "R8 ch1 cleared");
    // R4 free-running inverse
    wr(8'h44, 32'hFFFFFFFF); wr(8'h4C, 32'hFFFFFFFF);
    rd(8'h4C, 32'h00FFFFFF, "R2 ivh1 pad");
    wr(8'h40, 32'h3);
    idle(1);
    run_ticks(5);
    rd(8'h48, 32'hFFFFFFFA, "R4 inverse low = 5");
    rd(8'h50, 32'h00FFFFFF, "R4 inverse high = 0");
    rd(8'h04, 0, "R5 no spurious expiry");
    wait (q.size() == 0);
    #1 done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule